// File: doc/BRIEF.md
# Always-On Power Sequencing Controller

This controller sits in the always-on domain. It is powered whenever mains input is present and never switches itself off. It brings the other supply domains up and down through one enable per rail, and it watches one power-good status bit per rail. Rails are numbered by boot position. Index 0 is peripheral power, index 1 is low-voltage power and index 2 is the main processor module. The rail count is a parameter.

The controller has three inputs. The first is a mechanical power button, which it synchronises and debounces. The second is a shutdown-permission signal from the host processor. The third is the set of rail status bits. A short press while off starts boot. Each rail is enabled only after the previous rail reports good. A short press while running does not cut power: it raises an interrupt so host software can shut down cleanly, and the host then answers on the permission input. A long hold of the button forces power-off without any software involvement. Loss of a rail while running, or a rail that never comes good during boot, latches a fault bit and removes the rails in reverse order.

Top module: `pseq_ctrl`

## Requirements
- R1: After reset, a short button press while every enable is low sets `rail_en` to 3'b001, so the peripheral rail comes up first.
- R2: Rail i+1 is enabled only after rail i's power-good has been seen. The enables grow by at most one bit per cycle. `sys_run` goes high only once all three power-goods are high.
- R3: During boot, if the rail being waited on does not report good within PG_TIMEOUT cycles, `fault_flag` is set and all enables are removed.
- R4: Power-down clears the highest enabled rail first and then the others in falling index order, with exactly GAP_CYCLES cycles between successive removals. `rail_en` always keeps the form 0..01..1.
- R5: A short press while running sets `shdn_irq` and leaves all enables high.
- R6: While running, whether or not the interrupt is pending, a high `host_off` starts power-down and `shdn_irq` falls.
- R7: Holding the button for LONG_CYCLES while running forces power-down with no `host_off`. Releasing the button afterwards does not raise `shdn_irq` and does not restart boot.
- R8: Loss of any power-good while running sets `fault_flag`, and the first enable is removed on the cycle after the fault appears.
- R9: `fault_flag` stays set while off and clears only when the next boot starts.
- R10: A button pulse shorter than DEB_CYCLES cycles after synchronisation has no effect.
- R11: A long press while off does not start boot. A short press during boot is ignored: the enables are unchanged and no interrupt is raised.
- R12: In reset, all enables are low and `shdn_irq`, `fault_flag` and `sys_run` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| btn_in | input | 1 | Raw power button, high while pressed |
| host_off | input | 1 | Shutdown permission from the host processor |
| rail_pg | input | N_RAILS | Power-good per rail, asynchronous |
| rail_en | output | N_RAILS | Rail enables, bit 0 first in boot order |
| sys_run | output | 1 | All rails up and running |
| shdn_irq | output | 1 | Shutdown-request interrupt to the processor |
| fault_flag | output | 1 | Latched rail fault or boot timeout |

## Verification
The properties assume that reset is held across at least one clock edge. They also assume that the rail status bits are only meaningful for rails that are enabled. The bench meets both conditions. It holds reset for several cycles, and it models each rail so that its power-good follows that rail's enable one cycle later, gated by a per-rail mask. That mask creates the stuck-rail and dropped-rail cases. The button and `host_off` are changed on falling clock edges, and held for whole multiples of the debounce window, except in the deliberate glitch case.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
   typedef enum logic [2:0] {
      ST_OFF  = 3'd0,
      ST_UP   = 3'd1,
      ST_RUN  = 3'd2,
      ST_ASK  = 3'd3,
      ST_DOWN = 3'd4
   } pseq_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pseq_button.sv
module pseq_button #(
   parameter int unsigned DEB_CYCLES  = 10000,
   parameter int unsigned LONG_CYCLES = 15000000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_raw,
   output logic short_evt,
   output logic long_evt
);
   localparam int unsigned DW = $clog2(DEB_CYCLES) + 1;
   localparam int unsigned HW = $clog2(LONG_CYCLES) + 1;

   logic          btn_s;
   logic          held;
   logic [DW-1:0] dcnt;
   logic [HW-1:0] hcnt;
   logic          flip;

   pseq_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(btn_raw), .q(btn_s)
   );

   assign flip = (btn_s != held) && (dcnt == DW'(DEB_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held      <= 1'b0;
         dcnt      <= '0;
         hcnt      <= '0;
         short_evt <= 1'b0;
         long_evt  <= 1'b0;
      end else begin
         if (btn_s != held) begin
            if (flip) begin
               held <= btn_s;
               dcnt <= '0;
            end else begin
               dcnt <= dcnt + 1'b1;
            end
         end else begin
            dcnt <= '0;
         end

         if (!held)
            hcnt <= '0;
         else if (hcnt < HW'(LONG_CYCLES))
            hcnt <= hcnt + 1'b1;

         long_evt  <= held && (hcnt == HW'(LONG_CYCLES - 1));
         short_evt <= held && !btn_s && flip && (hcnt < HW'(LONG_CYCLES - 1));
      end
   end
endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
   import pseq_pkg::*;
#(
   parameter int unsigned N_RAILS    = 3,
   parameter int unsigned PG_TIMEOUT = 100000,
   parameter int unsigned GAP_CYCLES = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               short_evt,
   input  logic               long_evt,
   input  logic               host_off,
   input  logic [N_RAILS-1:0] pg,
   output logic [N_RAILS-1:0] rail_en,
   output logic               sys_run,
   output logic               shdn_irq,
   output logic               fault_flag
);
   localparam int unsigned IW   = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
   localparam int unsigned TW   = $clog2(max2(PG_TIMEOUT, GAP_CYCLES)) + 1;
   localparam logic [IW-1:0] TOP = IW'(N_RAILS - 1);

   pseq_state_t        st;
   logic [IW-1:0]      idx;
   logic [TW-1:0]      tmr;
   logic [N_RAILS-1:0] below;
   logic               lower_lost;
   logic               any_lost;

   always_comb begin
      below = rail_en;
      below[idx] = 1'b0;
   end
   assign lower_lost = |(below & ~pg);
   assign any_lost   = |(~pg);
   assign sys_run    = (st == ST_RUN) || (st == ST_ASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_OFF;
         idx        <= '0;
         tmr        <= '0;
         rail_en    <= '0;
         shdn_irq   <= 1'b0;
         fault_flag <= 1'b0;
      end else begin
         case (st)
            ST_OFF: begin
               if (short_evt) begin
                  fault_flag <= 1'b0;
                  rail_en    <= N_RAILS'(1);
                  idx        <= '0;
                  tmr        <= '0;
                  st         <= ST_UP;
               end
            end
            ST_UP: begin
               if (long_evt) begin
                  tmr <= '0;
                  st  <= ST_DOWN;
               end else if (lower_lost) begin
                  fault_flag <= 1'b1;
                  tmr        <= '0;
                  st         <= ST_DOWN;
               end else if (pg[idx]) begin
                  tmr <= '0;
                  if (idx == TOP) begin
                     st <= ST_RUN;
                  end else begin
                     idx               <= idx + 1'b1;
                     rail_en[idx + 1'b1] <= 1'b1;
                  end
               end else if (tmr == TW'(PG_TIMEOUT - 1)) begin
                  fault_flag <= 1'b1;
                  tmr        <= '0;
                  st         <= ST_DOWN;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_RUN, ST_ASK: begin
               if (any_lost) begin
                  fault_flag <= 1'b1;
                  shdn_irq   <= 1'b0;
                  tmr        <= '0;
                  st         <= ST_DOWN;
               end else if (long_evt || host_off) begin
                  shdn_irq <= 1'b0;
                  tmr      <= '0;
                  st       <= ST_DOWN;
               end else if (short_evt && st == ST_RUN) begin
                  shdn_irq <= 1'b1;
                  st       <= ST_ASK;
               end
            end
            ST_DOWN: begin
               if (tmr == '0) begin
                  rail_en[idx] <= 1'b0;
                  if (idx == '0) begin
                     st <= ST_OFF;
                  end else begin
                     idx <= idx - 1'b1;
                     tmr <= TW'(GAP_CYCLES - 1);
                  end
               end else begin
                  tmr <= tmr - 1'b1;
               end
            end
            default: st <= ST_OFF;
         endcase
      end
   end
endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl #(
   parameter int unsigned N_RAILS     = 3,
   parameter int unsigned DEB_CYCLES  = 10000,
   parameter int unsigned LONG_CYCLES = 15000000,
   parameter int unsigned PG_TIMEOUT  = 100000,
   parameter int unsigned GAP_CYCLES  = 1000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               btn_in,
   input  logic               host_off,
   input  logic [N_RAILS-1:0] rail_pg,
   output logic [N_RAILS-1:0] rail_en,
   output logic               sys_run,
   output logic               shdn_irq,
   output logic               fault_flag
);
   generate
      if (N_RAILS < 2) begin : g_bad_rails
         $error("pseq_ctrl: N_RAILS must be at least 2");
      end
      if (DEB_CYCLES < 1) begin : g_bad_deb
         $error("pseq_ctrl: DEB_CYCLES must be at least 1");
      end
      if (LONG_CYCLES <= DEB_CYCLES) begin : g_bad_long
         $error("pseq_ctrl: LONG_CYCLES must exceed DEB_CYCLES");
      end
      if (PG_TIMEOUT < 2 || GAP_CYCLES < 1) begin : g_bad_tmr
         $error("pseq_ctrl: timer limits out of range");
      end
   endgenerate

   logic [N_RAILS-1:0] pg_s;
   logic               off_s;
   logic               short_evt;
   logic               long_evt;

   pseq_sync #(.W(N_RAILS), .STAGES(SYNC_STAGES)) i_pg_sync (
      .clk(clk), .rst_n(rst_n), .d(rail_pg), .q(pg_s)
   );

   pseq_sync #(.W(1), .STAGES(SYNC_STAGES)) i_off_sync (
      .clk(clk), .rst_n(rst_n), .d(host_off), .q(off_s)
   );

   pseq_button #(
      .DEB_CYCLES(DEB_CYCLES), .LONG_CYCLES(LONG_CYCLES), .SYNC_STAGES(SYNC_STAGES)
   ) i_button (
      .clk(clk), .rst_n(rst_n), .btn_raw(btn_in),
      .short_evt(short_evt), .long_evt(long_evt)
   );

   pseq_fsm #(
      .N_RAILS(N_RAILS), .PG_TIMEOUT(PG_TIMEOUT), .GAP_CYCLES(GAP_CYCLES)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .short_evt(short_evt), .long_evt(long_evt), .host_off(off_s),
      .pg(pg_s), .rail_en(rail_en), .sys_run(sys_run),
      .shdn_irq(shdn_irq), .fault_flag(fault_flag)
   );
endmodule

// File: rtl/pseq_ctrl_chk.sv
module pseq_ctrl_chk #(
   parameter int unsigned N_RAILS = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_RAILS-1:0] rail_en,
   input logic               sys_run,
   input logic               shdn_irq,
   input logic               fault_flag
);
   // R4: enables keep thermometer form
   p_thermo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((rail_en & (rail_en + 1'b1)) == '0));

   // R2: enables grow by at most one rail per cycle
   p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rail_en) <= $countones($past(rail_en)) + 1);

   // R2: running only with all rails enabled
   p_run_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sys_run |-> (&rail_en));

   // R5: interrupt only while all rails are on
   p_irq_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_irq |-> (&rail_en));

   // R6: interrupt withdrawal coincides with leaving run
   p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shdn_irq) |-> !sys_run);

   // R8: fault is followed at once by a rail removal
   p_fault_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_flag) |=> ($countones(rail_en) < $countones($past(rail_en))));

   // R9: fault clears only as boot starts from all-off
   p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_flag) |-> ($past(rail_en) == '0));
endmodule

bind pseq_ctrl pseq_ctrl_chk #(.N_RAILS(N_RAILS)) i_pseq_chk (
   .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .sys_run(sys_run),
   .shdn_irq(shdn_irq), .fault_flag(fault_flag)
);

// File: tb/test_pseq_ctrl.sv
module test_pseq_ctrl;
   localparam int CLK_NS = 10;
   localparam int NR     = 3;
   localparam int DEB    = 4;
   localparam int LONG   = 200;
   localparam int TMO    = 150;
   localparam int GAP    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          btn = 1'b0;
   logic          host_off = 1'b0;
   logic [NR-1:0] pg = '0;
   logic [NR-1:0] allow = '0;
   logic [NR-1:0] rail_en;
   logic          sys_run, shdn_irq, fault_flag;
   int            total = 0;
   int            bad = 0;

   pseq_ctrl #(
      .N_RAILS(NR), .DEB_CYCLES(DEB), .LONG_CYCLES(LONG),
      .PG_TIMEOUT(TMO), .GAP_CYCLES(GAP), .SYNC_STAGES(2)
   ) i_pseq_ctrl (
      .clk(clk), .rst_n(rst_n), .btn_in(btn), .host_off(host_off),
      .rail_pg(pg), .rail_en(rail_en), .sys_run(sys_run),
      .shdn_irq(shdn_irq), .fault_flag(fault_flag)
   );

   always #(CLK_NS/2) clk = ~clk;

   // rail model: good one cycle after enable, masked per rail
   always @(posedge clk) pg <= rail_en & allow;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input int n);
      @(negedge clk) btn = 1'b1;
      tick(n);
      btn = 1'b0;
      tick(25);
   endtask

   task automatic watch_down(input string req);
      logic [NR-1:0] prev;
      int last;
      int drops;
      prev  = rail_en;
      last  = -1;
      drops = 0;
      for (int c = 0; c < 200; c++) begin
         @(negedge clk);
         if (rail_en != prev) begin
            chk(rail_en == (prev >> 1), req, "reverse order step", rail_en, prev >> 1);
            if (last >= 0) chk(c - last == GAP, req, "gap between removals", c - last, GAP);
            last = c;
            drops++;
            prev = rail_en;
         end
         if (rail_en == '0) break;
      end
      chk(drops == NR, req, "number of removals", drops, NR);
      chk(rail_en == '0, req, "all rails off", rail_en, 0);
   endtask

   task automatic boot_full();
      allow = '1;
      press(20);
      chk(sys_run == 1'b1, "R2", "boot reaches run", sys_run, 1);
   endtask

   task automatic t_reset();
      chk(rail_en == '0, "R12", "enables in reset", rail_en, 0);
      chk(!shdn_irq && !fault_flag && !sys_run, "R12", "flags in reset",
          {shdn_irq, fault_flag, sys_run}, 0);
   endtask

   task automatic t_glitch();
      @(negedge clk) btn = 1'b1;
      tick(2);
      btn = 1'b0;
      tick(30);
      chk(rail_en == '0, "R10", "glitch ignored", rail_en, 0);
   endtask

   task automatic t_boot_staged();
      allow = '0;
      press(20);
      chk(rail_en == 3'b001, "R1", "peripheral rail first", rail_en, 1);
      tick(40);
      chk(rail_en == 3'b001, "R2", "waits for rail 0 good", rail_en, 1);
      allow = 3'b001;
      tick(8);
      chk(rail_en == 3'b011, "R2", "low-voltage rail after rail 0", rail_en, 3);
      press(20);
      chk(rail_en == 3'b011 && !shdn_irq, "R11", "press during boot ignored",
          {shdn_irq, rail_en}, 3);
      allow = 3'b011;
      tick(8);
      chk(rail_en == 3'b111 && !sys_run, "R2", "processor rail, not yet run",
          {sys_run, rail_en}, 7);
      allow = 3'b111;
      tick(8);
      chk(sys_run == 1'b1, "R2", "run after last good", sys_run, 1);
   endtask

   task automatic t_irq_then_host();
      press(20);
      chk(shdn_irq == 1'b1, "R5", "interrupt on short press", shdn_irq, 1);
      chk(rail_en == 3'b111, "R5", "rails stay on", rail_en, 7);
      @(negedge clk) host_off = 1'b1;
      watch_down("R4");
      chk(shdn_irq == 1'b0, "R6", "interrupt withdrawn", shdn_irq, 0);
      chk(fault_flag == 1'b0, "R6", "no fault on clean shutdown", fault_flag, 0);
      host_off = 1'b0;
      tick(5);
   endtask

   task automatic t_long_run();
      boot_full();
      @(negedge clk) btn = 1'b1;
      tick(240);
      chk(rail_en == '0, "R7", "forced off while held", rail_en, 0);
      chk(fault_flag == 1'b0, "R7", "no fault on forced off", fault_flag, 0);
      btn = 1'b0;
      tick(30);
      chk(rail_en == '0 && !shdn_irq, "R7", "release has no effect",
          {shdn_irq, rail_en}, 0);
   endtask

   task automatic t_long_off();
      @(negedge clk) btn = 1'b1;
      tick(260);
      btn = 1'b0;
      tick(30);
      chk(rail_en == '0, "R11", "long press while off", rail_en, 0);
   endtask

   task automatic t_timeout();
      allow = 3'b001;
      press(20);
      tick(200);
      chk(fault_flag == 1'b1, "R3", "timeout fault", fault_flag, 1);
      chk(rail_en == '0, "R3", "rails removed on timeout", rail_en, 0);
      tick(50);
      chk(fault_flag == 1'b1, "R9", "fault held while off", fault_flag, 1);
      boot_full();
      chk(fault_flag == 1'b0, "R9", "fault cleared by new boot", fault_flag, 0);
   endtask

   task automatic t_pg_loss();
      @(negedge clk) allow = 3'b101;
      watch_down("R8");
      chk(fault_flag == 1'b1, "R8", "fault on rail loss", fault_flag, 1);
      allow = '0;
      tick(5);
   endtask

   task automatic t_direct_host();
      boot_full();
      chk(shdn_irq == 1'b0, "R6", "no interrupt before host off", shdn_irq, 0);
      @(negedge clk) host_off = 1'b1;
      watch_down("R6");
      host_off = 1'b0;
      tick(5);
   endtask

   initial begin
      #(CLK_NS * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(5);
      t_reset();
      @(negedge clk) rst_n = 1'b1;
      tick(3);
      t_glitch();
      t_boot_staged();
      t_irq_then_host();
      t_long_run();
      t_long_off();
      t_timeout();
      t_pg_loss();
      t_direct_host();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule